// File: doc/BRIEF.md
# XON/XOFF Software Flow Detector

This block sits on the receive path of a serial channel. It looks at every received character and decides whether the local transmitter may keep sending. Two programmable patterns are held: one that resumes transmission and one that suspends it. Each pattern is either a single byte or a pair of bytes that must arrive back to back. When the last byte of a pattern arrives, the block updates its transmit permission. That completing byte is taken out of the receive stream, and a one-cycle strobe reports it.

The four pattern bytes are guarded. They can be read or written only while the line control register, which is a byte held in this block, contains the unlock value hex BF. The line control register and the mode register can always be reached. Received bytes that are not consumed leave the block one cycle after they arrive, with their data unchanged.

Top module: `flow_xonxoff_detect`

## Requirements
- R1: After reset, the line control register, the mode register and all four pattern bytes read as zero, `tx_allow_o` is 1, and `rx_valid_o` and `ctrl_hit_o` are 0.
- R2: The register map is: address 0 is the line control register, address 1 is the mode register, address 4 is resume byte 1, address 5 is resume byte 2, address 6 is suspend byte 1 and address 7 is suspend byte 2. A write to addresses 4 to 7 takes effect only when the line control register holds hex BF at the write's clock edge. Otherwise the write is ignored.
- R3: A read of addresses 4 to 7 returns 0 unless the line control register holds hex BF. Addresses 2 and 3 always read 0.
- R4: Mode register bit 0 makes the resume pattern two bytes long, and bit 1 does the same for the suspend pattern. When a pattern's bit is 0, it is one byte long and only byte 1 is used. A received byte equal to that byte completes the pattern.
- R5: A two-byte pattern completes only when byte 2 is the received character that comes directly after a character equal to byte 1. Any other character in between cancels the partial match.
- R6: A character that completes a pattern is not forwarded. Instead, `ctrl_hit_o` pulses for one cycle, one cycle after the character arrives. Every other received character appears on `rx_valid_o`/`rx_data_o` one cycle later with its data unchanged.
- R7: In two-byte mode, the leading byte of a pattern is forwarded as ordinary data.
- R8: When one character completes the resume pattern and the suspend pattern at the same time, the suspend pattern takes effect.
- R9: `tx_allow_o` goes to 0 one cycle after a suspend completion and to 1 one cycle after a resume completion. It changes at no other time.
- R10: A cycle with `rx_valid_i` low neither forwards a character, nor matches a pattern, nor changes a partial match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| rx_valid_o | output | 1 | Forwarded character strobe |
| rx_data_o | output | 8 | Forwarded character |
| ctrl_hit_o | output | 1 | Flow-control character consumed |
| tx_allow_o | output | 1 | Transmitter permitted to send |

## Verification
The assertions assume that `rx_valid_i` is low throughout reset. They also assume that register reads are combinational on `reg_addr_i`, so a read check may sample at any point within the cycle. The bench holds the receive strobe low during reset and changes inputs only just after a rising edge. Random characters are drawn mostly from the programmed pattern bytes, which makes partial matches, broken pairs and back-to-back completions frequent. Random register writes switch the lock on and off so that both gated and ungated accesses occur while characters are arriving.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int DATA_W   = 8;
  localparam int NUM_PAT  = 2;
  localparam int PAT_XON  = 0;
  localparam int PAT_XOFF = 1;
  localparam int NUM_PREG = NUM_PAT * 2;
  localparam int PIDX_W   = $clog2(NUM_PREG);
  localparam int ADDR_W   = 3;
  localparam logic [ADDR_W-1:0] A_LCR  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_PAT  = 3'd4;
  typedef logic [NUM_PREG-1:0][DATA_W-1:0] pat_bank_t;
endpackage

// File: rtl/flow_regs.sv
module flow_regs
  import flow_pkg::*;
#(
  parameter logic [DATA_W-1:0] UNLOCK_VAL = 8'hBF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [DATA_W-1:0]  lcr_o,
  output logic [NUM_PAT-1:0] two_byte_o,
  output pat_bank_t          pat_o
);
  logic [DATA_W-1:0]  lcr_q;
  logic [NUM_PAT-1:0] mode_q;
  pat_bank_t          pat_q;
  logic               unlocked;
  logic               pat_sel;

  assign unlocked = (lcr_q == UNLOCK_VAL);
  assign pat_sel  = (addr_i >= A_PAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lcr_q  <= '0;
      mode_q <= '0;
    end else if (we_i) begin
      if (addr_i == A_LCR)  lcr_q  <= wdata_i;
      if (addr_i == A_MODE) mode_q <= wdata_i[NUM_PAT-1:0];
    end
  end

  for (genvar i = 0; i < NUM_PREG; i++) begin : g_preg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        pat_q[i] <= '0;
      else if (we_i && unlocked && addr_i == A_PAT + ADDR_W'(i))
        pat_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_LCR)
      rdata_o = lcr_q;
    else if (addr_i == A_MODE)
      rdata_o = {{(DATA_W-NUM_PAT){1'b0}}, mode_q};
    else if (pat_sel && unlocked)
      rdata_o = pat_q[addr_i[PIDX_W-1:0]];
  end

  assign lcr_o      = lcr_q;
  assign two_byte_o = mode_q;
  assign pat_o      = pat_q;
endmodule

// File: rtl/flow_matcher.sv
module flow_matcher
  import flow_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] first_i,
  input  logic [DATA_W-1:0] second_i,
  input  logic              two_byte_i,
  output logic              hit_o
);
  logic arm_q;
  logic eq_first;
  logic eq_second;

  assign eq_first  = (data_i == first_i);
  assign eq_second = (data_i == second_i);
  assign hit_o     = valid_i && (two_byte_i ? (arm_q && eq_second) : eq_first);

  // partial match lives exactly one received character
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      arm_q <= 1'b0;
    else if (valid_i)
      arm_q <= two_byte_i && eq_first;
  end
endmodule

// File: rtl/flow_txgate.sv
module flow_txgate
  import flow_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              xon_hit_i,
  input  logic              xoff_hit_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ctrl_hit_o,
  output logic              tx_allow_o
);
  logic any_hit;
  assign any_hit = xon_hit_i || xoff_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      data_o     <= '0;
      ctrl_hit_o <= 1'b0;
      tx_allow_o <= 1'b1;
    end else begin
      valid_o    <= valid_i && !any_hit;
      ctrl_hit_o <= any_hit;
      if (valid_i) data_o <= data_i;
      if (xoff_hit_i)     tx_allow_o <= 1'b0;
      else if (xon_hit_i) tx_allow_o <= 1'b1;
    end
  end
endmodule

// File: rtl/flow_xonxoff_detect.sv
module flow_xonxoff_detect
  import flow_pkg::*;
#(
  parameter logic [DATA_W-1:0] UNLOCK_VAL = 8'hBF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              ctrl_hit_o,
  output logic              tx_allow_o
);
  logic [DATA_W-1:0]  lcr_q;
  logic [NUM_PAT-1:0] two_byte;
  pat_bank_t          pat_q;
  logic [NUM_PAT-1:0] hit;

  flow_regs #(.UNLOCK_VAL(UNLOCK_VAL)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .lcr_o      (lcr_q),
    .two_byte_o (two_byte),
    .pat_o      (pat_q)
  );

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_match
    flow_matcher u_match (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (rx_valid_i),
      .data_i     (rx_data_i),
      .first_i    (pat_q[2*p]),
      .second_i   (pat_q[2*p+1]),
      .two_byte_i (two_byte[p]),
      .hit_o      (hit[p])
    );
  end

  flow_txgate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (rx_valid_i),
    .data_i     (rx_data_i),
    .xon_hit_i  (hit[PAT_XON]),
    .xoff_hit_i (hit[PAT_XOFF]),
    .valid_o    (rx_valid_o),
    .data_o     (rx_data_o),
    .ctrl_hit_o (ctrl_hit_o),
    .tx_allow_o (tx_allow_o)
  );
endmodule

// File: rtl/flow_xonxoff_detect_chk.sv
module flow_xonxoff_detect_chk
  import flow_pkg::*;
#(
  parameter logic [DATA_W-1:0] UNLOCK_VAL = 8'hBF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              rx_valid_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              rx_valid_o,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              ctrl_hit_o,
  input logic              tx_allow_o,
  input logic [DATA_W-1:0] lcr_i,
  input pat_bank_t         pat_i
);
  p_locked_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i >= A_PAT && lcr_i != UNLOCK_VAL) |=> $stable(pat_i));

  p_locked_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i >= A_PAT && lcr_i != UNLOCK_VAL) |-> reg_rdata_o == '0);

  p_consumed_dropped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_hit_o |-> !rx_valid_o);

  p_forward_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> ($past(rx_valid_i) && rx_data_o == $past(rx_data_i)));

  p_allow_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_hit_o |-> $stable(tx_allow_o));

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rx_valid_i) |-> (!ctrl_hit_o && !rx_valid_o));
endmodule

bind flow_xonxoff_detect flow_xonxoff_detect_chk #(.UNLOCK_VAL(UNLOCK_VAL)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .rx_valid_i  (rx_valid_i),
  .rx_data_i   (rx_data_i),
  .rx_valid_o  (rx_valid_o),
  .rx_data_o   (rx_data_o),
  .ctrl_hit_o  (ctrl_hit_o),
  .tx_allow_o  (tx_allow_o),
  .lcr_i       (lcr_q),
  .pat_i       (pat_q)
);

// File: tb/tb_flow_xonxoff_detect.sv
module tb_flow_xonxoff_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_valid_o;
  logic [7:0] rx_data_o;
  logic       ctrl_hit;
  logic       tx_allow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0] m_lcr;
  logic [1:0] m_mode;
  logic [7:0] m_pat [4];
  logic       m_arm [2];
  logic       m_allow;

  always #5 clk = ~clk;

  flow_xonxoff_detect dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .ctrl_hit_o(ctrl_hit), .tx_allow_o(tx_allow)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_hit(int p, logic [7:0] d);
    if (m_mode[p]) return m_arm[p] && d == m_pat[2*p+1];
    return d == m_pat[2*p];
  endfunction

  function automatic logic [7:0] m_read(logic [2:0] a);
    if (a == 3'd0) return m_lcr;
    if (a == 3'd1) return {6'd0, m_mode};
    if (a >= 3'd4 && m_lcr == 8'hBF) return m_pat[a-3'd4];
    return 8'h00;
  endfunction

  task automatic step(input bit we, input logic [2:0] a, input logic [7:0] wd,
                      input bit rv, input logic [7:0] rd, input string tag);
    bit xh, fh, e_valid, e_hit, e_allow;
    logic [7:0] old_lcr;
    reg_we = we; reg_addr = a; reg_wdata = wd; rx_valid = rv; rx_data = rd;
    xh = rv && m_hit(0, rd);
    fh = rv && m_hit(1, rd);
    e_valid = rv && !(xh || fh);
    e_hit   = xh || fh;
    e_allow = fh ? 1'b0 : (xh ? 1'b1 : m_allow);
    @(posedge clk); #1;
    old_lcr = m_lcr;
    if (rv) for (int p = 0; p < 2; p++) m_arm[p] = m_mode[p] && rd == m_pat[2*p];
    if (we) begin
      if (a == 3'd0) m_lcr = wd;
      if (a == 3'd1) m_mode = wd[1:0];
      if (a >= 3'd4 && old_lcr == 8'hBF) m_pat[a-3'd4] = wd;
    end
    m_allow = e_allow;
    reg_we = 1'b0; rx_valid = 1'b0;
    chk(rx_valid_o == e_valid, {tag, " valid"}, 32'(rx_valid_o), 32'(e_valid));
    chk(ctrl_hit == e_hit, {tag, " hit"}, 32'(ctrl_hit), 32'(e_hit));
    chk(tx_allow == e_allow, {tag, " allow"}, 32'(tx_allow), 32'(e_allow));
    if (e_valid) chk(rx_data_o == rd, {tag, " data"}, 32'(rx_data_o), 32'(rd));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    step(1'b1, a, d, 1'b0, 8'h00, tag);
  endtask

  task automatic rx(input logic [7:0] d, input string tag);
    step(1'b0, 3'd0, 8'h00, 1'b1, d, tag);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    logic [7:0] e;
    reg_addr = a; #1;
    e = m_read(a);
    chk(reg_rdata == e, tag, 32'(reg_rdata), 32'(e));
  endtask

  initial begin
    m_lcr = '0; m_mode = '0; m_allow = 1'b1;
    for (int i = 0; i < 4; i++) m_pat[i] = '0;
    for (int p = 0; p < 2; p++) m_arm[p] = 1'b0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(tx_allow == 1'b1, "R1 allow", 32'(tx_allow), 1);
    chk(rx_valid_o == 1'b0, "R1 valid", 32'(rx_valid_o), 0);
    chk(ctrl_hit == 1'b0, "R1 hit", 32'(ctrl_hit), 0);
    rd(3'd0, "R1 lcr"); rd(3'd1, "R1 mode");
    wr(3'd0, 8'hBF, "R2 unlock");
    for (int a = 4; a < 8; a++) rd(3'(a), "R1 pattern zero");
    // R2 writes through gate
    wr(3'd4, 8'h11, "R2"); wr(3'd5, 8'h22, "R2");
    wr(3'd6, 8'h13, "R2"); wr(3'd7, 8'h24, "R2");
    for (int a = 4; a < 8; a++) rd(3'(a), "R2 readback");
    wr(3'd0, 8'h03, "R3 lock");
    rd(3'd4, "R3 locked read"); rd(3'd2, "R3 hole");
    wr(3'd4, 8'h55, "R2 locked write");
    wr(3'd0, 8'hBF, "R2 unlock");
    rd(3'd4, "R2 locked write ignored");
    // R4 one-byte mode, R6 forwarding
    rx(8'h41, "R6 plain");
    rx(8'h13, "R4 suspend");
    rx(8'h13, "R9 repeat suspend");
    rx(8'h42, "R9 plain keeps state");
    rx(8'h11, "R4 resume");
    step(1'b0, 3'd0, 8'h00, 1'b0, 8'h13, "R10 idle strobe");
    // R5, R7 two-byte mode
    wr(3'd1, 8'h03, "R4 mode");
    rx(8'h13, "R7 leading byte forwarded");
    rx(8'h24, "R5 suspend pair");
    rx(8'h11, "R7 lead");
    rx(8'h41, "R5 broken pair");
    rx(8'h22, "R5 stale second");
    rx(8'h11, "R7 lead");
    step(1'b0, 3'd0, 8'h00, 1'b0, 8'h00, "R10 gap keeps arm");
    rx(8'h22, "R5 resume pair");
    // R8 priority
    wr(3'd1, 8'h00, "R4 mode");
    wr(3'd4, 8'h13, "R8 setup");
    rx(8'h13, "R8 suspend wins");
    wr(3'd4, 8'h11, "R8 restore");
    rx(8'h11, "R4 resume");
    // random
    for (int n = 0; n < 4000; n++) begin
      int sel = int'($urandom_range(0, 9));
      logic [7:0] alph [6] = '{8'h11, 8'h13, 8'h22, 8'h24, 8'h00, 8'h5A};
      logic [7:0] b = ($urandom_range(0, 4) == 0) ? 8'($urandom()) : alph[$urandom_range(0, 5)];
      if (sel == 0) begin
        logic [2:0] a = 3'($urandom_range(0, 7));
        logic [7:0] d = (a == 3'd0) ? (($urandom_range(0, 2) != 0) ? 8'hBF : 8'h03) : b;
        step(1'b1, a, d, ($urandom_range(0, 1) == 1), b, "R2 rnd");
      end else begin
        step(1'b0, 3'd0, 8'h00, (sel != 9), b, "R6 rnd");
      end
      rd(3'($urandom_range(0, 7)), "R3 rnd read");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule